// File: doc/BRIEF.md
# Fractional Output Divider with First-Period Skew

This block divides a fast input clock by a programmable ratio made of a 12-bit integer part N and a 30-bit fraction F, read as F / 2^30. It emits a one-cycle clock-enable pulse at the end of every divided period. It also drives a toggle output that stays high for roughly half of each period. Each period is either N or N+1 input ticks long. A 30-bit phase accumulator decides which: at the end of every period the fraction is added to the accumulator, and a carry out of bit 29 lengthens the next period by one tick. Over many periods the average ratio is exactly N + F / 2^30.

A skew offset delays the output relative to other channels that restart at the same moment. The counter is not preloaded for this. Instead, the first period after a restart is made longer by an integer number of ticks, and the skew fraction is folded into the accumulator during that period only. The skew value is captured while the divider is idle, so a new value takes effect at the next restart.

Three control bits choose the mode:
- Divider enable with own-path select gives the normal mode, where every input clock cycle is a tick.
- Divider enable with the previous-channel select gives the cascaded mode, where only cycles in which the neighbouring channel's pulse is high count as ticks.
- Any other combination leaves the divider unused, with its outputs idle.

An active-low synchronous divider reset also holds the outputs idle and restarts the divider.

Top module: `frac_skew_divider`

## Requirements
- R1: While `rstN` is low at a rising edge, `outPulse` and `outClk` are 0 after that edge. The divider restarts: the accumulator is cleared and the next period is treated as the first.
- R2: Normal mode is `divEn`=1, `selOwn`=1 and `selPrev`=0. In this mode, with F=0 and no skew, `outPulse` is high after the N-th rising edge that follows the release, and then once every N cycles.
- R3: With fraction F, each period lasts N or N+1 ticks. The extra tick is added when the sum of the accumulator and F carries out of bit 29. The accumulator starts at 0 after a restart and takes the low 30 bits of that sum at each period end. For example, N=3 with F=2^28 gives the lengths 3,3,3,4 repeating.
- R4: An integer divisor of 0 or 1 is treated as 2, so `outPulse` is never high in two consecutive cycles.
- R5: The first period after a restart lasts N + S + c ticks, where S is the skew integer and c is the carry of F plus the skew fraction. Later periods follow R3, starting from the low 30 bits of that sum.
- R6: Skew values are captured while the divider is idle. A change to `skewInt` or `skewFrac` while the divider runs has no effect until the next restart.
- R7: Cascaded mode is `divEn`=1 and `selPrev`=1, whatever the value of `selOwn`, so `selPrev` has priority over `selOwn`. In this mode a tick is a cycle with `prevPulse` high, and `outPulse` can only follow an edge at which `prevPulse` was high.
- R8: With `divEn`=0, or with both `selOwn` and `selPrev` at 0, the outputs are 0 one edge later and the divider restarts.
- R9: Within a period of L ticks, `outClk` goes to 1 after tick floor(L/2). It returns to 0 after tick L, on the same edge that raises `outPulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rstN | input | 1 | Divider reset, active low, synchronous |
| divEn | input | 1 | Divider enable |
| selOwn | input | 1 | Select the divider's own tick path (normal mode) |
| selPrev | input | 1 | Select the previous channel's pulse as tick (cascaded mode) |
| prevPulse | input | 1 | Clock-enable pulse from the previous channel |
| intDiv | input | 12 | Integer part of the divisor |
| fracDiv | input | 30 | Fractional part of the divisor, in units of 2^-30 |
| skewInt | input | 12 | Integer part of the first-period skew, in ticks |
| skewFrac | input | 30 | Fractional part of the first-period skew |
| outPulse | output | 1 | One-cycle pulse at the end of each divided period |
| outClk | output | 1 | Toggle output, high for roughly half of each period |

## Verification
The hardest case to reach from the ports is a skew change that must be ignored. The change has to arrive while the stretched first period is still running, and the divider must then be restarted so that the new value is seen to take effect. The stimulus releases the divider with a large skew integer and, three cycles later, clears both skew inputs. It then compares every later pulse against a period model that keeps the value captured at release. After that it forces a restart through the enable bit and checks that the first period now uses the new value. A second corner case is a skew fraction whose carry coincides with the divisor fraction. It is reached by choosing fractions whose sum passes 2^30, so that the first period gains an extra tick and the accumulator carries a non-zero residue into later periods.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_OWN     = 2'd1,
    MODE_CASCADE = 2'd2
  } fsd_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // divider idle: restart counter and accumulator, capture skew
    logic tick;    // one input tick counted this cycle
    logic wrap;    // this tick closes the current period
    logic first;   // current period is the first after a restart
  } fsd_strobe_t;

endpackage

// File: rtl/fsd_datapath.sv
module fsd_datapath
  import fsd_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 30,
  parameter bit SKEW_EN = 1'b1
) (
  input  logic              clk,
  input  fsd_strobe_t       strb,
  input  logic [INT_W-1:0]  intDiv,
  input  logic [FRAC_W-1:0] fracDiv,
  input  logic [INT_W-1:0]  skewInt,
  input  logic [FRAC_W-1:0] skewFrac,
  output logic              atLast,
  output logic              atHalf
);

  localparam int LEN_W = INT_W + 2;
  localparam int SUM_W = FRAC_W + 2;
  localparam logic [LEN_W-1:0] MIN_DIV = LEN_W'(2);

  logic [LEN_W-1:0]  tickCnt;
  logic [FRAC_W-1:0] phaseAcc;
  logic [INT_W-1:0]  skewIntEff;
  logic [FRAC_W-1:0] skewFracEff;

  // Skew shadow: loaded only while idle, frozen while running
  generate
    if (SKEW_EN) begin : g_skew
      logic [INT_W-1:0]  skewIntQ;
      logic [FRAC_W-1:0] skewFracQ;
      always_ff @(posedge clk) begin
        if (strb.clear) begin
          skewIntQ  <= skewInt;
          skewFracQ <= skewFrac;
        end
      end
      assign skewIntEff  = skewIntQ;
      assign skewFracEff = skewFracQ;
    end else begin : g_noskew
      assign skewIntEff  = '0;
      assign skewFracEff = '0;
    end
  endgenerate

  logic [LEN_W-1:0]  intEff;
  logic [LEN_W-1:0]  skewAdd;
  logic [FRAC_W-1:0] fracAdd;
  logic [SUM_W-1:0]  phaseSum;
  logic [1:0]        carryCnt;
  logic [LEN_W-1:0]  periodLen;
  logic [LEN_W-1:0]  lastIdx;
  logic [LEN_W-1:0]  halfIdx;

  always_comb begin
    intEff    = (LEN_W'(intDiv) < MIN_DIV) ? MIN_DIV : LEN_W'(intDiv);
    skewAdd   = strb.first ? LEN_W'(skewIntEff) : '0;
    fracAdd   = strb.first ? skewFracEff : '0;
    phaseSum  = SUM_W'(phaseAcc) + SUM_W'(fracDiv) + SUM_W'(fracAdd);
    carryCnt  = phaseSum[SUM_W-1:FRAC_W];
    periodLen = intEff + skewAdd + LEN_W'(carryCnt);
    lastIdx   = periodLen - LEN_W'(1);
    halfIdx   = (periodLen >> 1) - LEN_W'(1);
    atLast    = (tickCnt >= lastIdx);
    atHalf    = (tickCnt == halfIdx);
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      tickCnt  <= '0;
      phaseAcc <= '0;
    end else if (strb.wrap) begin
      tickCnt  <= '0;
      phaseAcc <= phaseSum[FRAC_W-1:0];
    end else if (strb.tick) begin
      tickCnt  <= tickCnt + LEN_W'(1);
    end
  end

endmodule

// File: rtl/fsd_control.sv
module fsd_control
  import fsd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        divEn,
  input  logic        selOwn,
  input  logic        selPrev,
  input  logic        prevPulse,
  input  logic        atLast,
  input  logic        atHalf,
  output fsd_strobe_t strb,
  output logic        outPulse,
  output logic        outClk
);

  fsd_mode_e mode;
  logic      running;
  logic      tick;
  logic      firstQ;

  // Mode decode: previous-channel select has priority over own path
  always_comb begin
    if (!divEn)       mode = MODE_OFF;
    else if (selPrev) mode = MODE_CASCADE;
    else if (selOwn)  mode = MODE_OWN;
    else              mode = MODE_OFF;
    running = rstN && (mode != MODE_OFF);
    tick    = running && ((mode == MODE_CASCADE) ? prevPulse : 1'b1);
    strb.clear = !running;
    strb.tick  = tick;
    strb.wrap  = tick && atLast;
    strb.first = firstQ;
  end

  always_ff @(posedge clk) begin
    if (!running) begin
      firstQ   <= 1'b1;
      outPulse <= 1'b0;
      outClk   <= 1'b0;
    end else begin
      outPulse <= strb.wrap;
      if (strb.wrap) begin
        firstQ <= 1'b0;
        outClk <= 1'b0;
      end else if (tick && atHalf) begin
        outClk <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/frac_skew_divider.sv
module frac_skew_divider
  import fsd_pkg::*;
#(
  parameter int INT_W   = 12,
  parameter int FRAC_W  = 30,
  parameter bit SKEW_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              divEn,
  input  logic              selOwn,
  input  logic              selPrev,
  input  logic              prevPulse,
  input  logic [INT_W-1:0]  intDiv,
  input  logic [FRAC_W-1:0] fracDiv,
  input  logic [INT_W-1:0]  skewInt,
  input  logic [FRAC_W-1:0] skewFrac,
  output logic              outPulse,
  output logic              outClk
);

  fsd_strobe_t strb;
  logic        atLast;
  logic        atHalf;

  fsd_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .divEn     (divEn),
    .selOwn    (selOwn),
    .selPrev   (selPrev),
    .prevPulse (prevPulse),
    .atLast    (atLast),
    .atHalf    (atHalf),
    .strb      (strb),
    .outPulse  (outPulse),
    .outClk    (outClk)
  );

  fsd_datapath #(
    .INT_W   (INT_W),
    .FRAC_W  (FRAC_W),
    .SKEW_EN (SKEW_EN)
  ) u_dp (
    .clk      (clk),
    .strb     (strb),
    .intDiv   (intDiv),
    .fracDiv  (fracDiv),
    .skewInt  (skewInt),
    .skewFrac (skewFrac),
    .atLast   (atLast),
    .atHalf   (atHalf)
  );

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker (
  input logic clk,
  input logic rstN,
  input logic divEn,
  input logic selOwn,
  input logic selPrev,
  input logic prevPulse,
  input logic outPulse,
  input logic outClk
);

  // R1: reset low forces idle outputs
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!outPulse && !outClk));

  // R4: divisor floor of two keeps pulses apart
  assert_no_back_to_back_R4: assert property (@(posedge clk) disable iff (!rstN)
    outPulse |=> !outPulse);

  // R7: in cascaded mode a pulse needs a previous-channel tick
  assert_cascade_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outPulse && $past(divEn && selPrev)) |-> $past(prevPulse));

  // R8: unused mode holds outputs idle
  assert_unused_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(divEn && (selOwn || selPrev)) |=> (!outPulse && !outClk));

  // R9: toggle output is low whenever the period pulse fires
  assert_clk_low_at_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    outPulse |-> !outClk);

endmodule

bind frac_skew_divider fsd_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .divEn     (divEn),
  .selOwn    (selOwn),
  .selPrev   (selPrev),
  .prevPulse (prevPulse),
  .outPulse  (outPulse),
  .outClk    (outClk)
);

// File: tb/frac_skew_divider_tb_top.sv
module frac_skew_divider_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        divEn;
  logic        selOwn;
  logic        selPrev;
  logic        prevPulse;
  logic [11:0] intDiv;
  logic [29:0] fracDiv;
  logic [11:0] skewInt;
  logic [29:0] skewFrac;
  logic        outPulse;
  logic        outClk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  frac_skew_divider dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .divEn     (divEn),
    .selOwn    (selOwn),
    .selPrev   (selPrev),
    .prevPulse (prevPulse),
    .intDiv    (intDiv),
    .fracDiv   (fracDiv),
    .skewInt   (skewInt),
    .skewFrac  (skewFrac),
    .outPulse  (outPulse),
    .outClk    (outClk)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Period length from the requirements (R3, R4, R5)
  function automatic int periodOf(input bit first, input longint acc, input longint skI,
                                  input longint skF, output longint nextAcc);
    longint s;
    longint n;
    s = acc + longint'(fracDiv) + (first ? skF : 0);
    n = (intDiv < 2) ? 2 : longint'(intDiv);
    nextAcc = s & ((longint'(1) << 30) - 1);
    return int'(n + (first ? skI : 0) + (s >> 30));
  endfunction

  // Release from idle, then compare every cycle against the period model.
  // prevPer>0 drives prevPulse once every prevPer cycles. At cycle chgAt the
  // skew inputs are cleared; the model keeps the skew captured at release.
  task automatic runCase(input string req, input int cycles, input int prevPer, input int chgAt);
    longint mAcc, nAcc, skI, skF;
    bit     mFirst;
    int     mCnt, mLen;
    logic   expP, expC, drv;
    bit     casc;
    skI = longint'(skewInt);
    skF = longint'(skewFrac);
    casc = selPrev;
    mAcc = 0; mFirst = 1; mCnt = 0; expC = 1'b0;
    mLen = periodOf(mFirst, mAcc, skI, skF, nAcc);
    @(negedge clk);
    divEn = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      drv = (prevPer > 0) && ((i % prevPer) == 0);
      prevPulse = drv;
      if (i == chgAt) begin
        skewInt  = '0;
        skewFrac = '0;
      end
      @(negedge clk);
      expP = 1'b0;
      if (!casc || drv) begin
        if (mCnt == mLen - 1) begin
          expP = 1'b1;
          expC = 1'b0;
          mCnt = 0;
          mAcc = nAcc;
          mFirst = 0;
          mLen = periodOf(mFirst, mAcc, skI, skF, nAcc);
        end else begin
          if (mCnt == (mLen / 2) - 1) expC = 1'b1;
          mCnt++;
        end
      end
      check(req, "outPulse", outPulse, expP);
      check("R9", "outClk", outClk, expC);
    end
    prevPulse = 1'b0;
    divEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input int n, input longint f, input int sI, input longint sF,
                       input bit own, input bit prev);
    intDiv = 12'(n); fracDiv = 30'(f); skewInt = 12'(sI); skewFrac = 30'(sF);
    selOwn = own; selPrev = prev;
  endtask

  task automatic testReset();
    rstN = 1'b0; divEn = 1'b1; setup(3, 0, 0, 0, 1, 0);
    repeat (4) @(negedge clk);
    check("R1", "outPulse in reset", outPulse, 1'b0);
    check("R1", "outClk in reset", outClk, 1'b0);
    divEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testMidReset();
    setup(4, 0, 0, 0, 1, 0);
    divEn = 1'b1;
    repeat (6) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "outPulse after mid-run reset", outPulse, 1'b0);
    check("R1", "outClk after mid-run reset", outClk, 1'b0);
    divEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    runCase("R1", 20, 0, -1);  // restart begins with a full first period
  endtask

  task automatic testUnused(input string req, input bit en, input bit own, input bit prev);
    int seen = 0;
    setup(2, 0, 0, 0, own, prev);
    divEn = en;
    prevPulse = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (outPulse || outClk) seen++;
    end
    prevPulse = 1'b0;
    divEn = 1'b0;
    checks++;
    if (seen != 0) begin
      errors++;
      $display("FAIL %s unused mode active cycles actual=%0d expected=0", req, seen);
    end
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; divEn = 1'b0; selOwn = 1'b0; selPrev = 1'b0; prevPulse = 1'b0;
    intDiv = '0; fracDiv = '0; skewInt = '0; skewFrac = '0;
    testReset();                                               // R1
    setup(5, 0, 0, 0, 1, 0);          runCase("R2", 40, 0, -1);
    setup(3, 1 << 28, 0, 0, 1, 0);    runCase("R3", 60, 0, -1);
    setup(7, 30'h2AAAAAAB, 0, 0, 1, 0); runCase("R3", 80, 0, -1);
    setup(0, 0, 0, 0, 1, 0);          runCase("R4", 30, 0, -1);
    setup(1, 1 << 29, 0, 0, 1, 0);    runCase("R4", 30, 0, -1);
    setup(4, 1 << 29, 5, 3 << 28, 1, 0); runCase("R5", 60, 0, -1);
    setup(6, 0, 9, 1 << 29, 1, 0);    runCase("R5", 50, 0, -1);
    setup(3, 0, 10, 1 << 29, 1, 0);   runCase("R6", 50, 0, 3);
    runCase("R6", 30, 0, -1);         // restart picks up the cleared skew
    setup(3, 1 << 29, 0, 0, 0, 1);    runCase("R7", 80, 3, -1);
    setup(2, 0, 2, 0, 1, 1);          runCase("R7", 60, 2, -1);
    testUnused("R8", 1'b0, 1'b1, 1'b0);
    testUnused("R8", 1'b1, 1'b0, 1'b0);
    testMidReset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule